// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block fetches and executes a three-instruction subset of an 8-bit accumulator machine. Instructions come from a byte-wide program ROM with one cycle of read latency. It keeps a program counter, an accumulator and eight working registers. It runs two kinds of instruction:

- Two-byte loads. An opcode byte is followed by an immediate byte. The immediate goes into the accumulator or into one of the working registers.
- One-byte adds. These add a working register to the accumulator and leave the wrapped 8-bit sum in the accumulator.

The program counter advances by one for every instruction byte consumed. An opcode outside the supported set raises a sticky illegal flag. The counter then freezes on that byte until reset.

The block sits next to a synchronous ROM. It drives the ROM address from its program counter and takes the returned byte one cycle later. The accumulator, every working register and the program counter are brought out as observation ports, so surrounding logic can see the architectural state at any time.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is high and just after it drops, the program counter, ROM address, accumulator, all eight working registers and the illegal flag are zero.
- R2: Opcode 74h loads the byte that follows it into the accumulator and advances the program counter by two.
- R3: Opcode 78h+n (n = opcode bits 2:0) loads the byte that follows it into working register n, leaves the other seven registers and the accumulator unchanged, and advances the program counter by two.
- R4: Opcode 28h+n replaces the accumulator with (accumulator + register n) mod 256, leaves register n unchanged, and advances the program counter by one.
- R5: The ROM address always equals the program counter. Each instruction byte takes two cycles: one to present the address and one to consume the returned byte. An instruction's result is visible 2 cycles (one-byte) or 4 cycles (two-byte) after it is first addressed. For a two-byte load, the program counter reaches opcode+1 after 3 cycles, with the destination not yet written.
- R6: Any opcode byte other than 74h, 78h–7Fh and 28h–2Fh sets the illegal flag two cycles after it is addressed. The flag stays set, and the program counter, accumulator and registers stay frozen, until reset clears them.
- R7: The program counter wraps from its all-ones value to zero.
- R8: The byte following a load opcode is treated only as data. It never raises the illegal flag, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | ADDR_W | Program ROM byte address |
| rom_data | input | DATA_W | Byte returned by the ROM one cycle after its address |
| acc_o | output | DATA_W | Accumulator |
| regs_o | output | 8*DATA_W | Working registers, register n at bits n*DATA_W +: DATA_W |
| pc_o | output | ADDR_W | Program counter |
| illegal_o | output | 1 | Sticky illegal-opcode flag |

## Verification
The bench builds the block with ADDR_W = 10 and DATA_W = 8. The narrow counter lets a ROM made entirely of add opcodes walk the full address space and wrap back to zero within about two thousand cycles. Every one of the 256 byte values is placed as the first opcode and classed as legal or illegal. A two-dimensional sweep of accumulator and register operands, rotated across all eight register selects, checks the wrapped sum against arithmetic done in the bench. Directed programs pin down the cycle at which a load lands and the freeze after an illegal byte.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int REG_SEL_W = 3;
  localparam int NUM_REGS  = 1 << REG_SEL_W;

  localparam logic [7:0] OPC_LOAD_ACC = 8'h74;
  localparam logic [7:0] OPC_LOAD_REG = 8'h78;
  localparam logic [7:0] OPC_ADD_REG  = 8'h28;

  typedef enum logic [2:0] {
    ST_ADDR_OP,
    ST_OPCODE,
    ST_ADDR_IMM,
    ST_IMM,
    ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_LOAD_ACC,
    OP_LOAD_REG,
    OP_ADD_REG,
    OP_BAD
  } op_kind_e;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]    opcode,
  output op_kind_e             kind,
  output logic [REG_SEL_W-1:0] sel
);

  localparam logic [DATA_W-1:0] LDA_C = DATA_W'(OPC_LOAD_ACC);
  localparam logic [DATA_W-1:0] LDR_C = DATA_W'(OPC_LOAD_REG);
  localparam logic [DATA_W-1:0] ADD_C = DATA_W'(OPC_ADD_REG);

  assign sel = opcode[REG_SEL_W-1:0];

  always_comb begin
    if (opcode == LDA_C)
      kind = OP_LOAD_ACC;
    else if (opcode[DATA_W-1:REG_SEL_W] == LDR_C[DATA_W-1:REG_SEL_W])
      kind = OP_LOAD_REG;
    else if (opcode[DATA_W-1:REG_SEL_W] == ADD_C[DATA_W-1:REG_SEL_W])
      kind = OP_ADD_REG;
    else
      kind = OP_BAD;
  end

endmodule

// File: rtl/acc_seq_pc.sv
module acc_seq_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (inc)
      pc_q <= pc_q + ADDR_W'(1);
  end

  assign pc_o = pc_q;

  // R5: the counter moves only when told to
  p_pc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(pc_o));

endmodule

// File: rtl/acc_seq_regfile.sv
module acc_seq_regfile
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [REG_SEL_W-1:0]         waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [REG_SEL_W-1:0]         raddr,
  output logic [DATA_W-1:0]            rdata,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0]             wen;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
    assign wen[i] = we && (waddr == REG_SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wen[i]) regs_q[i] <= wdata;
      end
    end
  end

  assign rdata  = regs_q[raddr];
  assign regs_o = regs_q;

  // R3: without a write request no register changes
  p_regs_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_o));

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [ADDR_W-1:0]          rom_addr,
  input  logic [DATA_W-1:0]          rom_data,
  output logic [DATA_W-1:0]          acc_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [ADDR_W-1:0]          pc_o,
  output logic                       illegal_o
);

  seq_state_e           state_q, state_d;
  op_kind_e             dec_kind, pend_kind_q;
  logic [REG_SEL_W-1:0] dec_sel, pend_sel_q;
  logic [DATA_W-1:0]    acc_q, rd_data;
  logic                 illegal_q;
  logic                 pc_inc;
  logic                 reg_we;
  logic [ADDR_W-1:0]    pc;

  acc_seq_decode #(.DATA_W(DATA_W)) u_dec (
    .opcode (rom_data),
    .kind   (dec_kind),
    .sel    (dec_sel)
  );

  acc_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .inc  (pc_inc),
    .pc_o (pc)
  );

  assign reg_we = (state_q == ST_IMM) && (pend_kind_q == OP_LOAD_REG);

  acc_seq_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .waddr  (pend_sel_q),
    .wdata  (rom_data),
    .raddr  (dec_sel),
    .rdata  (rd_data),
    .regs_o (regs_o)
  );

  assign pc_inc = ((state_q == ST_OPCODE) && (dec_kind != OP_BAD)) ||
                  (state_q == ST_IMM);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ADDR_OP:  state_d = ST_OPCODE;
      ST_OPCODE: begin
        if (dec_kind == OP_BAD)          state_d = ST_HALT;
        else if (dec_kind == OP_ADD_REG) state_d = ST_ADDR_OP;
        else                             state_d = ST_ADDR_IMM;
      end
      ST_ADDR_IMM: state_d = ST_IMM;
      ST_IMM:      state_d = ST_ADDR_OP;
      ST_HALT:     state_d = ST_HALT;
      default:     state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ADDR_OP;
      pend_kind_q <= OP_BAD;
      pend_sel_q  <= '0;
      acc_q       <= '0;
      illegal_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_OPCODE) begin
        pend_kind_q <= dec_kind;
        pend_sel_q  <= dec_sel;
        if (dec_kind == OP_ADD_REG) acc_q <= acc_q + rd_data;
        if (dec_kind == OP_BAD)     illegal_q <= 1'b1;
      end
      if ((state_q == ST_IMM) && (pend_kind_q == OP_LOAD_ACC))
        acc_q <= rom_data;
    end
  end

  assign rom_addr  = pc;
  assign pc_o      = pc;
  assign acc_o     = acc_q;
  assign illegal_o = illegal_q;

  // R6: the flag never drops without reset
  p_illegal_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> illegal_o);

  // R6: a halted sequencer keeps its program counter
  p_pc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> $stable(pc_o));

  // R6: a halted sequencer keeps its accumulator
  p_acc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> $stable(acc_o));

  // R4: an add replaces the accumulator with the wrapped sum
  p_add_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPCODE && dec_kind == OP_ADD_REG) |=>
      acc_o == $past(acc_o) + $past(rd_data));

  // R5: a consumed legal opcode steps the counter by one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPCODE && dec_kind != OP_BAD) |=>
      pc_o == $past(pc_o) + ADDR_W'(1));

endmodule

// File: tb/tb_acc_seq_top.sv
module tb_acc_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 8;
  localparam int NREG       = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int WD_CYCLES  = 190000;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [ADDR_W-1:0]        rom_addr;
  logic [DATA_W-1:0]        rom_data;
  logic [DATA_W-1:0]        acc_o;
  logic [NREG*DATA_W-1:0]   regs_o;
  logic [ADDR_W-1:0]        pc_o;
  logic                     illegal_o;

  logic [7:0] rom [DEPTH];

  int nchk  = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  acc_seq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .acc_o     (acc_o),
    .regs_o    (regs_o),
    .pc_o      (pc_o),
    .illegal_o (illegal_o)
  );

  function automatic int reg_val(input int n);
    return int'(regs_o[n*DATA_W +: DATA_W]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < DEPTH; i++) rom[i] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got %0d expected %0d", WD_CYCLES, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: dirty the state, then reset and look at every output
    fill(8'h00);
    rom[0] = 8'h74; rom[1] = 8'h9C; rom[2] = 8'h7B; rom[3] = 8'h44;
    do_reset();
    run(10);
    do_reset();
    check("R1 pc", int'(pc_o), 0);
    check("R1 rom_addr", int'(rom_addr), 0);
    check("R1 acc", int'(acc_o), 0);
    check("R1 illegal", int'(illegal_o), 0);
    for (int n = 0; n < NREG; n++) check("R1 reg", reg_val(n), 0);

    // R5/R3: load every register, watch the cycle a load lands
    fill(8'h00);
    for (int n = 0; n < NREG; n++) begin
      rom[2*n]     = 8'h78 + 8'(n);
      rom[2*n + 1] = 8'(n*8'h23 + 8'h11);
      rom[16 + n]  = 8'h28 + 8'(n);
    end
    do_reset();
    run(3);
    check("R5 pc mid-load", int'(pc_o), 1);
    check("R5 r0 not yet written", reg_val(0), 0);
    run(1);
    check("R5 r0 written at cycle 4", reg_val(0), 8'h11);
    check("R5 pc after load", int'(pc_o), 2);
    check("R3 r1 untouched", reg_val(1), 0);
    run(28);
    for (int n = 0; n < NREG; n++)
      check("R3 reg load", reg_val(n), (n*8'h23 + 8'h11) & 8'hFF);
    check("R3 acc untouched", int'(acc_o), 0);
    check("R3 pc", int'(pc_o), 16);
    run(1);
    check("R5 acc before add lands", int'(acc_o), 0);
    run(1);
    check("R4 first add", int'(acc_o), 8'h11);
    check("R4 pc step", int'(pc_o), 17);
    run(14);
    begin
      int sum = 0;
      for (int n = 0; n < NREG; n++) sum += n*8'h23 + 8'h11;
      check("R4 chained adds", int'(acc_o), sum & 8'hFF);
    end
    check("R4 pc after adds", int'(pc_o), 24);
    check("R4 r7 unchanged", reg_val(7), (7*8'h23 + 8'h11) & 8'hFF);

    // R2/R3/R4: operand sweep with rotating register select
    for (int a = 0; a < 256; a += 15) begin
      for (int b = 0; b < 256; b += 3) begin
        int n;
        n = (a + b) % NREG;
        rom[0] = 8'h74; rom[1] = 8'(a);
        rom[2] = 8'h78 + 8'(n); rom[3] = 8'(b);
        rom[4] = 8'h28 + 8'(n); rom[5] = 8'h00;
        do_reset();
        run(4);
        check("R2 acc load", int'(acc_o), a);
        check("R2 pc", int'(pc_o), 2);
        run(6);
        check("R4 sum", int'(acc_o), (a + b) & 8'hFF);
        check("R3 dest reg", reg_val(n), b);
        check("R4 pc", int'(pc_o), 5);
      end
    end

    // R6/R5: every byte value as the first opcode
    for (int op = 0; op < 256; op++) begin
      bit legal;
      legal = (op == 8'h74) || ((op >> 3) == 5'b01111) || ((op >> 3) == 5'b00101);
      fill(8'h00);
      rom[0] = 8'(op); rom[1] = 8'h5A;
      do_reset();
      run(2);
      check("R6 illegal classify", int'(illegal_o), legal ? 0 : 1);
      check("R5 pc after opcode", int'(pc_o), legal ? 1 : 0);
    end

    // R6: halt persists, then reset clears it
    fill(8'h00);
    rom[0] = 8'h74; rom[1] = 8'h10; rom[2] = 8'hA3; rom[3] = 8'h28;
    do_reset();
    run(6);
    check("R6 flag set", int'(illegal_o), 1);
    check("R6 pc frozen", int'(pc_o), 2);
    run(20);
    check("R6 flag sticky", int'(illegal_o), 1);
    check("R6 pc still frozen", int'(pc_o), 2);
    check("R6 acc kept", int'(acc_o), 8'h10);
    do_reset();
    check("R6 reset clears flag", int'(illegal_o), 0);
    check("R6 reset clears acc", int'(acc_o), 0);

    // R8: immediates that look like bad opcodes are data
    fill(8'h00);
    rom[0] = 8'h74; rom[1] = 8'hFF; rom[2] = 8'h78; rom[3] = 8'hA5;
    do_reset();
    run(8);
    check("R8 no illegal", int'(illegal_o), 0);
    check("R8 acc", int'(acc_o), 8'hFF);
    check("R8 r0", reg_val(0), 8'hA5);
    check("R8 pc", int'(pc_o), 4);

    // R7: walk the whole address space with adds of R0
    fill(8'h28);
    do_reset();
    run(2*(DEPTH-1));
    check("R7 pc at top", int'(pc_o), DEPTH-1);
    run(2);
    check("R7 pc wrapped", int'(pc_o), 0);
    check("R7 no illegal", int'(illegal_o), 0);
    check("R7 acc", int'(acc_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule